// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an 8-bit dual-slope analog-to-digital converter. A start request launches a conversion. The block first holds the comparator-nulling switch closed for a fixed number of clocks. It then routes the analog input to the integrator and waits for the comparator to report a nonzero integrator output.

Once the comparator reports nonzero, the block counts one full counter cycle of integration, ending when the counter wraps to zero. It then switches the integrator input to the negative reference. Counting continues from the wrapped value until the comparator reports that the integrator has returned to zero. The count reached at that point is the conversion result.

If the integrator is still nonzero after the counter has wrapped a second time, the block flags over-range. The integrator, comparator and reference stay outside the block.

Top module: `dslope_seq`

## Requirements
- R1: While rst_ni is low, and after it is released until a start is accepted, autozero_o, sel_ref_o, busy_o, done_o and ovr_o are 0 and result_o is 0.
- R2: A start_i sampled high while the block is idle sets busy_o and autozero_o from the next cycle. autozero_o stays high for exactly AZ_CYCLES cycles, and sel_ref_o stays 0 throughout.
- R3: After auto-zero, sel_ref_o stays 0 (analog input selected) until integ_nz_i is sampled high. Counting starts in the next cycle and lasts exactly 2^CNT_W cycles, after which sel_ref_o goes to 1.
- R4: While sel_ref_o is 1, every cycle with integ_nz_i high adds one to the count. At the first cycle with integ_nz_i low, the block behaves as follows in the next cycle:
  - result_o takes the count modulo 2^CNT_W;
  - ovr_o goes to 0;
  - done_o pulses high for one cycle;
  - sel_ref_o and busy_o drop.
- R5: Full scale: when exactly 2^CNT_W de-integrate cycles have integ_nz_i high, the result is 0 (8'h00) with ovr_o 0.
- R6: Quarter scale: when 2^(CNT_W-2) de-integrate cycles have integ_nz_i high, the result is 8'h40.
- R7: Over-range: if integ_nz_i is still high in the cycle after the second counter wrap (more than 2^CNT_W high cycles), the next cycle ends the conversion with result_o all ones, ovr_o 1 and a done_o pulse.
- R8: A start_i while busy_o is 1 has no effect on the sequence. result_o and ovr_o change only in the cycle in which done_o is high.
- R9: The cycle in which done_o is high is an idle cycle, so a start_i sampled then begins a new auto-zero in the next cycle.
- R10: integ_nz_i is ignored during auto-zero: no counting takes place and the result is unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| integ_nz_i | input | 1 | Comparator: integrator output is nonzero |
| autozero_o | output | 1 | Comparator-nulling switch enable |
| sel_ref_o | output | 1 | Integrator input select: 0 analog input, 1 negative reference |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result is updated |
| result_o | output | CNT_W | Conversion result |
| ovr_o | output | 1 | Over-range flag for the last result |

## Verification
Two events can meet in one cycle: the end of a conversion (done_o pulse) and the acceptance of the next start request, because the done cycle is already idle. The bench provokes this by holding start_i high through the end of a conversion. It judges the case by requiring busy_o low with done_o high, followed by autozero_o high in the very next cycle. A second coincidence is the counter wrap in the de-integrate phase landing in the same cycle as the comparator's return to zero. Inputs sized to exactly full scale and one count beyond it must separate a zero result from over-range.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_AZERO,
    PH_ARM,
    PH_INTEG,
    PH_DEINT
  } phase_e;
endpackage

// File: rtl/dslope_az_timer.sv
module dslope_az_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tc_o
);
  localparam int TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tc_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/dslope_phase_cnt.sv
module dslope_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  // next increment rolls all ones back to zero
  assign wrap_o = en_i && (&cnt_q);
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         nz_i,
  input  logic         az_tc_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  output phase_e       phase_o,
  output logic         cnt_clr_o,
  output logic         cnt_en_o,
  output logic [W-1:0] result_o,
  output logic         ovr_o,
  output logic         done_o
);
  phase_e       ph_q;
  logic         wrapped_q;
  logic [W-1:0] res_q;
  logic         ovr_q;
  logic         done_q;

  assign cnt_clr_o = (ph_q == PH_IDLE) || (ph_q == PH_ARM);
  assign cnt_en_o  = (ph_q == PH_INTEG) ||
                     ((ph_q == PH_DEINT) && nz_i && !wrapped_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      wrapped_q <= 1'b0;
      res_q     <= '0;
      ovr_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          wrapped_q <= 1'b0;
          if (start_i) ph_q <= PH_AZERO;
        end
        PH_AZERO: if (az_tc_i) ph_q <= PH_ARM;
        PH_ARM:   if (nz_i) ph_q <= PH_INTEG;
        PH_INTEG: if (wrap_i) ph_q <= PH_DEINT;
        PH_DEINT: begin
          if (!nz_i) begin
            res_q  <= cnt_i;
            ovr_q  <= 1'b0;
            done_q <= 1'b1;
            ph_q   <= PH_IDLE;
          end else if (wrapped_q) begin
            // still not rezeroed after second wrap
            res_q  <= '1;
            ovr_q  <= 1'b1;
            done_q <= 1'b1;
            ph_q   <= PH_IDLE;
          end else if (wrap_i) begin
            wrapped_q <= 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = ph_q;
  assign result_o = res_q;
  assign ovr_o    = ovr_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int AZ_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             integ_nz_i,
  output logic             autozero_o,
  output logic             sel_ref_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o,
  output logic             ovr_o
);
  phase_e           phase;
  logic             az_tc;
  logic             cnt_clr;
  logic             cnt_en;
  logic             cnt_wrap;
  logic [CNT_W-1:0] cnt;

  dslope_az_timer #(.CYCLES(AZ_CYCLES)) u_az (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (phase == PH_AZERO),
    .tc_o   (az_tc)
  );

  dslope_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .cnt_o  (cnt),
    .wrap_o (cnt_wrap)
  );

  dslope_fsm #(.W(CNT_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .nz_i      (integ_nz_i),
    .az_tc_i   (az_tc),
    .wrap_i    (cnt_wrap),
    .cnt_i     (cnt),
    .phase_o   (phase),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .result_o  (result_o),
    .ovr_o     (ovr_o),
    .done_o    (done_o)
  );

  assign autozero_o = (phase == PH_AZERO);
  assign sel_ref_o  = (phase == PH_DEINT);
  assign busy_o     = (phase != PH_IDLE);
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             autozero_o,
  input logic             sel_ref_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] result_o,
  input logic             ovr_o
);
  p_az_in_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    autozero_o |-> busy_o && !sel_ref_o);

  p_ref_after_integ_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_ref_o) |-> $past(busy_o && !autozero_o));

  p_done_ends_deint_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(sel_ref_o));

  p_ref_drop_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_ref_o) |-> done_o);

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ovr_all_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovr_o) |-> (&result_o));

  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o) && $stable(ovr_o));
endmodule

bind dslope_seq dslope_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .autozero_o (autozero_o),
  .sel_ref_o  (sel_ref_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .ovr_o      (ovr_o)
);

// File: tb/sim_dslope_seq.sv
`timescale 1ns/1ps
module sim_dslope_seq;
  localparam int CNT_W = 8;
  localparam int AZ    = 16;
  localparam int FS    = 1 << CNT_W;
  // reference magnitude covers the two arm cycles before counting starts
  localparam int REF   = FS + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic force_nz = 1'b0;
  logic integ_nz;
  logic autozero, sel_ref, busy, done, ovr;
  logic [CNT_W-1:0] result;

  int vin = 0;
  int vint = 0;
  int vectors = 0;
  int misses = 0;
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  dslope_seq #(.CNT_W(CNT_W), .AZ_CYCLES(AZ)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .integ_nz_i(integ_nz),
    .autozero_o(autozero), .sel_ref_o(sel_ref), .busy_o(busy),
    .done_o(done), .result_o(result), .ovr_o(ovr)
  );

  // behavioural integrator and comparator
  assign integ_nz = (vint > 0) || force_nz;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)              vint <= 0;
    else if (autozero)        vint <= 0;
    else if (busy && !sel_ref) vint <= vint + vin;
    else if (sel_ref)         vint <= vint - REF;
  end

  // reference model: 0 idle, 1 autozero, 2 arm, 3 integrate, 4 de-integrate
  int m_ph = 0, m_az = 0, m_ic = 0, m_dc = 0, m_res = 0;
  bit m_done = 1'b0, m_ovr = 1'b0;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph <= 0; m_az <= 0; m_ic <= 0; m_dc <= 0;
      m_res <= 0; m_done <= 1'b0; m_ovr <= 1'b0;
    end else begin
      m_done <= 1'b0;
      if (m_ph == 0) begin
        if (start) begin m_ph <= 1; m_az <= 0; end
      end else if (m_ph == 1) begin
        m_az <= m_az + 1;
        if (m_az == AZ - 1) m_ph <= 2;
      end else if (m_ph == 2) begin
        if (integ_nz) begin m_ph <= 3; m_ic <= 0; end
      end else if (m_ph == 3) begin
        m_ic <= m_ic + 1;
        if (m_ic == FS - 1) begin m_ph <= 4; m_dc <= 0; end
      end else begin
        if (!integ_nz) begin
          m_ph <= 0; m_res <= m_dc % FS; m_ovr <= 1'b0; m_done <= 1'b1;
        end else if (m_dc == FS) begin
          m_ph <= 0; m_res <= FS - 1; m_ovr <= 1'b1; m_done <= 1'b1;
        end else begin
          m_dc <= m_dc + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R2 autozero_o", int'(autozero), int'(m_ph == 1));
      chk("R3 sel_ref_o", int'(sel_ref), int'(m_ph == 4));
      chk("R8 busy_o", int'(busy), int'(m_ph != 0));
      chk("R4 done_o", int'(done), int'(m_done));
      chk("R4 result_o", int'(result), m_res);
      chk("R7 ovr_o", int'(ovr), int'(m_ovr));
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk("R4 done timeout", 0, 1);
  endtask

  task automatic convert(input int v, input string tag, input int exp_res,
                         input int exp_ovr, input bit noisy, input bit az_nz);
    vin = v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (az_nz) force_nz = 1'b1;
    for (int i = 0; i < AZ + 4; i++) begin
      @(negedge clk);
      if (!autozero) force_nz = 1'b0;
      if (noisy) start = (i % 3 == 0);
    end
    force_nz = 1'b0;
    start = 1'b0;
    wait_done();
    chk({tag, " result"}, int'(result), exp_res);
    chk({tag, " ovr"}, int'(ovr), exp_ovr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset outputs", int'({autozero, sel_ref, done, ovr}), 0);
    rst_ni = 1'b1;
    live = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", int'({autozero, sel_ref, busy, done, ovr}), 0);

    convert(FS / 4, "R6 quarter", 8'h40, 0, 1'b0, 1'b0);
    convert(FS, "R5 full", 0, 0, 1'b0, 1'b0);
    convert(FS + 1, "R7 over by one", FS - 1, 1, 1'b0, 1'b0);
    convert(300, "R7 over", FS - 1, 1, 1'b0, 1'b0);
    convert(1, "R4 one count", 1, 0, 1'b0, 1'b0);
    convert(FS - 1, "R4 max count", FS - 1, 0, 1'b0, 1'b0);
    convert(100, "R8 start while busy", 100, 0, 1'b1, 1'b0);
    convert(37, "R10 nz during autozero", 37, 0, 1'b0, 1'b1);

    // R9: start held high across the done cycle
    vin = 50;
    @(negedge clk); start = 1'b1;
    wait_done();
    chk("R9 done cycle idle", int'(busy), 0);
    chk("R9 result", int'(result), 50);
    @(negedge clk);
    chk("R9 restart autozero", int'(autozero), 1);
    start = 1'b0;
    wait_done();
    chk("R9 second result", int'(result), 50);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule